// File: doc/BRIEF.md
# PTP Event Packet Classifier

This block looks at the header fields of a received frame after the frame has been parsed. It decides whether the frame is a precision-time-protocol event message whose arrival time should be captured. A header parser presents one strobe per frame together with the EtherType, the IP protocol, the UDP source and destination ports, the PTP version and the PTP message type. One cycle later the classifier raises a single-cycle stamp request for the capture logic that follows it.

Static control inputs choose what counts as a match. There are four classification modes: timestamping off; version-1 PTP over UDP with one selected message type; version-2 event messages carried directly in Ethernet or over UDP; and stamping of every frame. The Ethernet path has two separate enable bits, and both must be set. The UDP path can also require the source port to be the event port. When that check is off, the source port is ignored.

Top module: `ptp_evt_classifier`

## Requirements
- R1: `stamp_req` rises in the clock cycle after a cycle with `hdr_valid` high and a matching frame, and stays high for exactly one cycle per strobe. A cycle without `hdr_valid` produces no request in the following cycle.
- R2: With `cfg_mode` = 0 (off), no frame ever produces a request, whatever its fields are.
- R3: With `cfg_mode` = 3 (all), every strobe produces a request, whatever the frame fields are.
- R4: A frame is an Ethernet-carried PTP frame only when `eth_type` = 0x88F7 and both `cfg_l2_filt_en` and `cfg_l2_ts_en` are 1. If either enable is 0, such a frame does not take the Ethernet path.
- R5: A frame is a UDP-carried PTP frame only when `eth_type` = 0x0800, `ip_proto` = 17 and `udp_dst` = 319. Any other EtherType, protocol or destination port fails this match.
- R6: When `cfg_src_chk` = 1, the UDP match also requires `udp_src` = 319. When `cfg_src_chk` = 0, `udp_src` has no effect.
- R7: With `cfg_mode` = 1 (v1 over UDP), a request needs a UDP-carried frame with `ptp_ver` = 1 and `ptp_msg` equal to the selected type. `cfg_v1_sel` = 0 selects type 0 (Sync) and `cfg_v1_sel` = 1 selects type 1 (Delay_Req). Ethernet-carried frames never match in this mode.
- R8: With `cfg_mode` = 2 (v2 events), a request needs `ptp_ver` = 2, `ptp_msg` in 0..3, and either an Ethernet-carried (R4) or a UDP-carried (R5, R6) frame.
- R9: With `cfg_mode` = 2, general messages (`ptp_msg` of 4 or more) and frames whose version is not 2 never produce a request.
- R10: While `rst_n` is low, `stamp_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Mode: 0 off, 1 v1 over UDP, 2 v2 events, 3 all frames |
| cfg_v1_sel | input | 1 | v1 message select: 0 Sync, 1 Delay_Req |
| cfg_l2_filt_en | input | 1 | Ethernet-path filter enable |
| cfg_l2_ts_en | input | 1 | Ethernet-path timestamp enable |
| cfg_src_chk | input | 1 | Require UDP source port 319 |
| hdr_valid | input | 1 | Parsed-header strobe, one cycle per frame |
| eth_type | input | 16 | EtherType |
| ip_proto | input | 8 | IP protocol number |
| udp_src | input | 16 | UDP source port |
| udp_dst | input | 16 | UDP destination port |
| ptp_ver | input | 4 | PTP version |
| ptp_msg | input | 4 | PTP message type |
| stamp_req | output | 1 | One-cycle timestamp capture request |

## Verification
Each frame's result is due exactly one clock after its strobe, because one register sits between the header fields and `stamp_req`. The driver applies one item on each falling edge and pushes its expected bit into a queue, including the idle cycles. The monitor samples 5 ns after every rising edge and pops one entry for each edge, so every result is compared in the cycle it is due. Back-to-back strobes and idle cycles are also compared, which covers the one-cycle pulse width.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

  typedef enum logic [1:0] {
    CLS_OFF    = 2'd0,
    CLS_V1_L4  = 2'd1,
    CLS_V2_EVT = 2'd2,
    CLS_ALL    = 2'd3
  } cls_mode_e;

  // Event messages occupy the low message-type codes.
  function automatic logic msg_is_event(input logic [3:0] msg, input logic [3:0] max_evt);
    return msg <= max_evt;
  endfunction

  // v1 selector to message-type code: 0 -> Sync (0), 1 -> Delay_Req (1).
  function automatic logic [3:0] v1_code(input logic sel);
    return sel ? 4'd1 : 4'd0;
  endfunction

endpackage

// File: rtl/ptp_l2_match.sv
module ptp_l2_match #(
  parameter int          ETYPE_W   = 16,
  parameter logic [15:0] PTP_ETYPE = 16'h88F7
) (
  input  logic [ETYPE_W-1:0] eth_type,
  input  logic               filt_en,
  input  logic               ts_en,
  output logic               hit
);
  localparam logic [ETYPE_W-1:0] KEY = ETYPE_W'(PTP_ETYPE);

  function automatic logic l2_eval(input logic [ETYPE_W-1:0] et, input logic fe, input logic te);
    return (et == KEY) && fe && te;
  endfunction

  assign hit = l2_eval(eth_type, filt_en, ts_en);
endmodule

// File: rtl/ptp_l4_match.sv
module ptp_l4_match #(
  parameter int          ETYPE_W   = 16,
  parameter int          PROTO_W   = 8,
  parameter int          PORT_W    = 16,
  parameter logic [15:0] IP_ETYPE  = 16'h0800,
  parameter int          UDP_PROTO = 17,
  parameter int          EVT_PORT  = 319
) (
  input  logic [ETYPE_W-1:0] eth_type,
  input  logic [PROTO_W-1:0] ip_proto,
  input  logic [PORT_W-1:0]  udp_src,
  input  logic [PORT_W-1:0]  udp_dst,
  input  logic               src_chk,
  output logic               dst_ok,
  output logic               src_ok,
  output logic               hit
);
  localparam logic [ETYPE_W-1:0] IPK   = ETYPE_W'(IP_ETYPE);
  localparam logic [PROTO_W-1:0] PROTK = PROTO_W'(UDP_PROTO);
  localparam logic [PORT_W-1:0]  PORTK = PORT_W'(EVT_PORT);

  function automatic logic port_eq(input logic [PORT_W-1:0] p);
    return p == PORTK;
  endfunction

  logic carrier_ok;
  assign carrier_ok = (eth_type == IPK) && (ip_proto == PROTK);
  assign dst_ok     = port_eq(udp_dst);
  // Source port masked unless the check is switched on.
  assign src_ok     = !src_chk || port_eq(udp_src);
  assign hit        = carrier_ok && dst_ok && src_ok;
endmodule

// File: rtl/ptp_mode_select.sv
module ptp_mode_select
  import ptp_cls_pkg::*;
#(
  parameter int VER_W   = 4,
  parameter int MSG_W   = 4,
  parameter int V1_VER  = 1,
  parameter int V2_VER  = 2,
  parameter int MAX_EVT = 3
) (
  input  cls_mode_e          mode,
  input  logic [VER_W-1:0]   ver,
  input  logic [MSG_W-1:0]   msg,
  input  logic               v1_sel,
  input  logic               l2_hit,
  input  logic               l4_hit,
  output logic               is_event,
  output logic               take
);
  localparam logic [VER_W-1:0] V1K = VER_W'(V1_VER);
  localparam logic [VER_W-1:0] V2K = VER_W'(V2_VER);

  assign is_event = msg_is_event(4'(msg), 4'(MAX_EVT));

  always_comb begin
    take = 1'b0;
    unique case (mode)
      CLS_OFF:    take = 1'b0;
      CLS_V1_L4:  take = l4_hit && (ver == V1K) && (4'(msg) == v1_code(v1_sel));
      CLS_V2_EVT: take = (l2_hit || l4_hit) && (ver == V2K) && is_event;
      CLS_ALL:    take = 1'b1;
      default:    take = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier
  import ptp_cls_pkg::*;
#(
  parameter int          ETYPE_W   = 16,
  parameter int          PROTO_W   = 8,
  parameter int          PORT_W    = 16,
  parameter int          VER_W     = 4,
  parameter int          MSG_W     = 4,
  parameter logic [15:0] PTP_ETYPE = 16'h88F7,
  parameter logic [15:0] IP_ETYPE  = 16'h0800,
  parameter int          UDP_PROTO = 17,
  parameter int          EVT_PORT  = 319
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_v1_sel,
  input  logic               cfg_l2_filt_en,
  input  logic               cfg_l2_ts_en,
  input  logic               cfg_src_chk,
  input  logic               hdr_valid,
  input  logic [ETYPE_W-1:0] eth_type,
  input  logic [PROTO_W-1:0] ip_proto,
  input  logic [PORT_W-1:0]  udp_src,
  input  logic [PORT_W-1:0]  udp_dst,
  input  logic [VER_W-1:0]   ptp_ver,
  input  logic [MSG_W-1:0]   ptp_msg,
  output logic               stamp_req
);
  cls_mode_e mode_q;
  logic l2_hit, l4_hit, l4_dst_ok, l4_src_ok, evt_msg, take;

  assign mode_q = cls_mode_e'(cfg_mode);

  ptp_l2_match #(.ETYPE_W(ETYPE_W), .PTP_ETYPE(PTP_ETYPE)) u_l2 (
    .eth_type (eth_type),
    .filt_en  (cfg_l2_filt_en),
    .ts_en    (cfg_l2_ts_en),
    .hit      (l2_hit)
  );

  ptp_l4_match #(
    .ETYPE_W(ETYPE_W), .PROTO_W(PROTO_W), .PORT_W(PORT_W),
    .IP_ETYPE(IP_ETYPE), .UDP_PROTO(UDP_PROTO), .EVT_PORT(EVT_PORT)
  ) u_l4 (
    .eth_type (eth_type),
    .ip_proto (ip_proto),
    .udp_src  (udp_src),
    .udp_dst  (udp_dst),
    .src_chk  (cfg_src_chk),
    .dst_ok   (l4_dst_ok),
    .src_ok   (l4_src_ok),
    .hit      (l4_hit)
  );

  ptp_mode_select #(.VER_W(VER_W), .MSG_W(MSG_W)) u_sel (
    .mode     (mode_q),
    .ver      (ptp_ver),
    .msg      (ptp_msg),
    .v1_sel   (cfg_v1_sel),
    .l2_hit   (l2_hit),
    .l4_hit   (l4_hit),
    .is_event (evt_msg),
    .take     (take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) stamp_req <= 1'b0;
    else        stamp_req <= hdr_valid && take;
  end
endmodule

// File: rtl/ptp_cls_checker.sv
module ptp_cls_checker #(
  parameter int PORT_W   = 16,
  parameter int MSG_W    = 4,
  parameter int EVT_PORT = 319
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic [1:0]        cfg_mode,
  input logic              cfg_l2_filt_en,
  input logic              cfg_l2_ts_en,
  input logic              cfg_src_chk,
  input logic [PORT_W-1:0] udp_src,
  input logic [MSG_W-1:0]  ptp_msg,
  input logic              l2_hit,
  input logic              l4_hit,
  input logic              stamp_req
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !stamp_req);
  assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cfg_mode == 2'd0) |=> !stamp_req);
  assert_all_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cfg_mode == 2'd3) |=> stamp_req);
  assert_l2_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_l2_filt_en && cfg_l2_ts_en) |-> !l2_hit);
  assert_src_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src_chk && udp_src != PORT_W'(EVT_PORT)) |-> !l4_hit);
  assert_general_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cfg_mode == 2'd2 && ptp_msg > MSG_W'(3)) |=> !stamp_req);
endmodule

bind ptp_evt_classifier ptp_cls_checker #(
  .PORT_W(PORT_W), .MSG_W(MSG_W), .EVT_PORT(EVT_PORT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hdr_valid      (hdr_valid),
  .cfg_mode       (cfg_mode),
  .cfg_l2_filt_en (cfg_l2_filt_en),
  .cfg_l2_ts_en   (cfg_l2_ts_en),
  .cfg_src_chk    (cfg_src_chk),
  .udp_src        (udp_src),
  .ptp_msg        (ptp_msg),
  .l2_hit         (l2_hit),
  .l4_hit         (l4_hit),
  .stamp_req      (stamp_req)
);

// File: tb/sim_ptp_evt_classifier.sv
module sim_ptp_evt_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_v1_sel = 1'b0, cfg_l2_filt_en = 1'b0, cfg_l2_ts_en = 1'b0, cfg_src_chk = 1'b0;
  logic hdr_valid = 1'b0;
  logic [15:0] eth_type = '0;
  logic [7:0]  ip_proto = '0;
  logic [15:0] udp_src = '0, udp_dst = '0;
  logic [3:0]  ptp_ver = '0, ptp_msg = '0;
  logic stamp_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ptp_evt_classifier u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_v1_sel(cfg_v1_sel),
    .cfg_l2_filt_en(cfg_l2_filt_en), .cfg_l2_ts_en(cfg_l2_ts_en), .cfg_src_chk(cfg_src_chk),
    .hdr_valid(hdr_valid), .eth_type(eth_type), .ip_proto(ip_proto),
    .udp_src(udp_src), .udp_dst(udp_dst), .ptp_ver(ptp_ver), .ptp_msg(ptp_msg),
    .stamp_req(stamp_req)
  );

  // Independent reference: written from the requirements.
  function automatic bit predict(input logic [1:0] m, input bit sel, input bit fe, input bit te,
                                 input bit sc, input logic [15:0] et, input logic [7:0] pr,
                                 input logic [15:0] sp, input logic [15:0] dp,
                                 input logic [3:0] v, input logic [3:0] mt);
    bit eth_ok, udp_ok;
    eth_ok = fe && te && (et == 16'h88F7);
    udp_ok = (et == 16'h0800) && (pr == 8'd17) && (dp == 16'd319);
    if (sc && sp != 16'd319) udp_ok = 0;
    if (m == 2'd3) return 1;
    if (m == 2'd1) return udp_ok && v == 4'd1 && mt == {3'b000, sel};
    if (m == 2'd2) return (eth_ok || udp_ok) && v == 4'd2 && mt < 4'd4;
    return 0;
  endfunction

  task automatic frame(input string tag, input logic [1:0] m, input bit sel, input bit fe,
                       input bit te, input bit sc, input logic [15:0] et, input logic [7:0] pr,
                       input logic [15:0] sp, input logic [15:0] dp,
                       input logic [3:0] v, input logic [3:0] mt);
    @(negedge clk);
    cfg_mode = m; cfg_v1_sel = sel; cfg_l2_filt_en = fe; cfg_l2_ts_en = te; cfg_src_chk = sc;
    eth_type = et; ip_proto = pr; udp_src = sp; udp_dst = dp; ptp_ver = v; ptp_msg = mt;
    hdr_valid = 1'b1;
    exp_q.push_back(predict(m, sel, fe, te, sc, et, pr, sp, dp, v, mt));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    hdr_valid = 1'b0;
    exp_q.push_back(1'b0);
    tag_q.push_back(tag);
  endtask

  // Monitor: result of the item driven before each rising edge.
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (stamp_req !== e) begin
        failures++;
        $display("FAIL %s stamp_req actual=%0b expected=%0b", t, stamp_req, e);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (stamp_req !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset stamp_req actual=%0b expected=0", stamp_req);
    end
    rst_n = 1'b1;
    idle("R1");
    // R3: all mode stamps arbitrary frames
    frame("R3", 2'd3, 0, 0, 0, 0, 16'h1234, 8'd6, 16'd5, 16'd6, 4'd9, 4'd12);
    frame("R3", 2'd3, 0, 0, 0, 1, 16'h0000, 8'd0, 16'd0, 16'd0, 4'd0, 4'd0);
    // R2: off mode ignores a perfect match
    frame("R2", 2'd0, 0, 1, 1, 0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0);
    frame("R2", 2'd0, 0, 1, 1, 0, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd1, 4'd0);
    idle("R1");
    // R4: Ethernet path enables
    frame("R4", 2'd2, 0, 1, 1, 0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0);
    frame("R4", 2'd2, 0, 0, 1, 0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0);
    frame("R4", 2'd2, 0, 1, 0, 0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0);
    frame("R4", 2'd2, 0, 1, 1, 0, 16'h88F8, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0);
    idle("R1");
    // R5: UDP path fields
    frame("R5", 2'd2, 0, 0, 0, 0, 16'h0800, 8'd17, 16'd5000, 16'd319, 4'd2, 4'd1);
    frame("R5", 2'd2, 0, 0, 0, 0, 16'h0800, 8'd17, 16'd5000, 16'd320, 4'd2, 4'd1);
    frame("R5", 2'd2, 0, 0, 0, 0, 16'h0800, 8'd6,  16'd5000, 16'd319, 4'd2, 4'd1);
    frame("R5", 2'd2, 0, 0, 0, 0, 16'h86DD, 8'd17, 16'd5000, 16'd319, 4'd2, 4'd1);
    // R6: source-port check
    frame("R6", 2'd2, 0, 0, 0, 1, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd2, 4'd2);
    frame("R6", 2'd2, 0, 0, 0, 1, 16'h0800, 8'd17, 16'd1234, 16'd319, 4'd2, 4'd2);
    frame("R6", 2'd2, 0, 0, 0, 0, 16'h0800, 8'd17, 16'd1234, 16'd319, 4'd2, 4'd2);
    idle("R1");
    // R8 / R9: v2 event versus general and wrong version
    frame("R8", 2'd2, 0, 1, 1, 0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd3);
    frame("R9", 2'd2, 0, 1, 1, 0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd4);
    frame("R9", 2'd2, 0, 0, 0, 0, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd2, 4'd8);
    frame("R9", 2'd2, 0, 1, 1, 0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd1, 4'd0);
    // R7: v1 single message type over UDP
    frame("R7", 2'd1, 0, 0, 0, 0, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd1, 4'd0);
    frame("R7", 2'd1, 0, 0, 0, 0, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd1, 4'd1);
    frame("R7", 2'd1, 1, 0, 0, 0, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd1, 4'd1);
    frame("R7", 2'd1, 1, 0, 0, 0, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd1, 4'd0);
    frame("R7", 2'd1, 0, 1, 1, 0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd1, 4'd0);
    frame("R7", 2'd1, 0, 0, 0, 0, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0);
    idle("R1");
    // R1: back-to-back strobes give one pulse each, then quiet
    frame("R1", 2'd3, 0, 0, 0, 0, 16'h0000, 8'd0, 16'd0, 16'd0, 4'd0, 4'd0);
    frame("R1", 2'd3, 0, 0, 0, 0, 16'h0000, 8'd0, 16'd0, 16'd0, 4'd0, 4'd0);
    idle("R1");
    idle("R1");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule